// File: doc/BRIEF.md
# Frame-Synchronous Handshake Channel Receiver

This block is the receive end of a byte-wide handshake channel that moves one byte per frame on a shared serial bus. On every frame strobe it samples the incoming byte and the active-low transmit flag, `mx_n`. It drives back the active-low acknowledge flag, `mr_n`. Accepted bytes are placed in a holding register for a processor. Sticky status bits report a new byte and the end of a message, and both are ORed onto an interrupt line.

A message starts when the transmit flag goes active after the line has been idle for at least two frames. Each later byte is marked by the flag going inactive for exactly one frame and then active again. The receiver holds off its acknowledge until the processor has read the holding register. The first acknowledge is a plain drop of `mr_n` to active. Every later acknowledge is one inactive frame followed by active. Two inactive transmit frames in a row end the message. The processor controls the receiver with an enable bit, `mrc`. Clearing that bit forces the acknowledge flag inactive. When this is done after the first acknowledge, the transfer is aborted.

Top module: `mon_rx`

## Requirements
- R1: While `rst_n` is low on a clock edge, `mr_n` is set to 1, `rx_data` to 0, and `sts_mdr`, `sts_mer` and `irq` to 0.
- R2: No message is in progress and no read is pending. The transmit flag is sampled active (0) after at least two inactive frames. In that frame the byte is stored in `rx_data`, a message begins and `sts_mdr` is set, whatever the values of `mrc` and `mre`.
- R3: After the first byte of a message is read (`rd_stb` high while a read is pending), `mr_n` goes to 0 at the first frame strobe where `mrc` is 1. It does not first make an inactive frame.
- R4: Inside a message, a byte is taken only on a frame where the transmit flag is active and was inactive in exactly the one frame before. It is also taken only if `mrc` is 1 and no read is pending. A flag held active never yields a new byte. Such a byte sets `sts_mdr` only when `mre` is 1.
- R5: Once the first acknowledge has been given, a read causes the next frame strobe (with `mrc` at 1) to drive `mr_n` to 1. The frame strobe after that drives it back to 0.
- R6: While a read is pending, no acknowledge is started and `rx_data` keeps its value, even if a new byte arrives.
- R7: Inside a message, the transmit flag sampled inactive in two consecutive frames ends the message. It sets `sts_mer` only when `mre` is 1.
- R8: A frame strobe with `mrc` at 0 drives `mr_n` to 1. If this happens inside a message after an acknowledge has been given, the message is aborted. Later single-gap bytes are then not stored until a new message starts.
- R9: Status bits stay set until `st_rd` is pulsed. A set coinciding with `st_rd` wins. `irq` is the OR of `sts_mdr` and `sts_mer`. Status is only set on a frame strobe.
- R10: `mx_n` and `rx_byte` have no effect on any output in cycles without `frame_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse marking the frame sample point |
| rx_byte | input | DATA_W | Channel byte of the current frame |
| mx_n | input | 1 | Transmit flag from the sender, active low |
| mrc | input | 1 | Receive enable control bit |
| mre | input | 1 | Status enable for all reports except the first byte |
| rd_stb | input | 1 | Processor read of the holding register |
| st_rd | input | 1 | Processor read of status, which clears it |
| mr_n | output | 1 | Acknowledge flag to the sender, active low |
| rx_data | output | DATA_W | Holding register |
| sts_mdr | output | 1 | Sticky byte-received status |
| sts_mer | output | 1 | Sticky end-of-message status |
| irq | output | 1 | OR of the status bits |

## Verification
If the inactive-run counter held a wrong value, it would show at the next frame strobe. The receiver would then either take a byte the sender did not mark, or miss one. Either error is visible in `rx_data` and `sts_mdr` one clock after that strobe. A wrong acknowledge state shows up as a wrong `mr_n` level at the following frame strobe: a missing inactive pulse, or an acknowledge given before the read. A message flag stuck in the wrong state shows up in two ways. An abort that fails to stop storage, or an end of message that never raises `sts_mer`, each appears within two frames.

// File: rtl/mon_rx_pkg.sv
// Shared types for the handshake channel receiver.
// Assumes nothing beyond being compiled before the modules that import it.
package mon_rx_pkg;
    // Acknowledge sequencer states
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_WAIT  = 2'd1,
        ACK_PULSE = 2'd2
    } ack_st_e;
endpackage

// File: rtl/mon_rx_mxdet.sv
// Transmit-flag run detector. It counts consecutive inactive frames of mx_n
// (saturating at EOM_FRAMES) and decodes, for the current frame strobe:
// a message start, a single-gap new byte, and the end of a message.
// Assumes frame_stb is a single-cycle pulse and EOM_FRAMES >= 2.
module mon_rx_mxdet #(
    parameter int EOM_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic mx_n,
    output logic start_o,
    output logic gap1_o,
    output logic eom_o
);
    localparam int RUN_W = $clog2(EOM_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(EOM_FRAMES);
    localparam logic [RUN_W-1:0] RUN_EOM = RUN_W'(EOM_FRAMES - 1);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic [RUN_W-1:0] run;

    // Count inactive frames; an idle line is assumed at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= RUN_SAT;
        end else if (frame_stb) begin
            if (!mx_n) begin
                run <= '0;
            end else if (run != RUN_SAT) begin
                run <= run + RUN_ONE;
            end
        end
    end

    // Decode the events of this frame from the previous run length
    always_comb begin
        start_o = frame_stb && !mx_n && (run == RUN_SAT);
        gap1_o  = frame_stb && !mx_n && (run == RUN_ONE);
        eom_o   = frame_stb &&  mx_n && (run == RUN_EOM);
    end
endmodule

// File: rtl/mon_rx_ack.sv
// Acknowledge sequencer. It drives mr_n. A read request arms it. At the next
// enabled frame it either drops mr_n straight to active (first byte) or sends
// one inactive frame and then active. mrc low forces mr_n inactive.
// Assumes ack_req is only raised when a byte is waiting to be acknowledged.
module mon_rx_ack
    import mon_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic mrc,
    input  logic ack_req,
    input  logic abort,
    output logic mr_n,
    output logic engaged
);
    ack_st_e st;
    logic    mr_q;

    // Sequence the acknowledge flag once per frame; a read arms the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ACK_IDLE;
            mr_q <= 1'b1;
        end else begin
            if (frame_stb) begin
                if (!mrc) begin
                    mr_q <= 1'b1;
                    if (abort || st == ACK_PULSE) st <= ACK_IDLE;
                end else begin
                    case (st)
                        ACK_WAIT: begin
                            if (mr_q) begin
                                mr_q <= 1'b0;
                                st   <= ACK_IDLE;
                            end else begin
                                mr_q <= 1'b1;
                                st   <= ACK_PULSE;
                            end
                        end
                        ACK_PULSE: begin
                            mr_q <= 1'b0;
                            st   <= ACK_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
            if (ack_req) st <= ACK_WAIT;
        end
    end

    // Acknowledge has been given at least once in this exchange
    always_comb begin
        engaged = !mr_q || (st == ACK_PULSE);
        mr_n    = mr_q;
    end

    // R8
    mrc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mrc) |=> mr_n);

    // R5
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mrc && st == ACK_PULSE && !ack_req) |=> !mr_n);
endmodule

// File: rtl/mon_rx_stat.sv
// Sticky status bank. Each bit is set by its set pulse and cleared by the
// shared read strobe; a set wins over a coinciding clear.
// Assumes set pulses are already gated by any enable.
module mon_rx_stat #(
    parameter int N_STS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STS-1:0] set_i,
    input  logic             clr_i,
    output logic [N_STS-1:0] sts_o,
    output logic             irq_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N_STS; gi++) begin : g_bit
            // Hold one sticky status bit
            always_ff @(posedge clk) begin
                if (!rst_n)           sts_o[gi] <= 1'b0;
                else if (set_i[gi])   sts_o[gi] <= 1'b1;
                else if (clr_i)       sts_o[gi] <= 1'b0;
            end
        end
    endgenerate

    // Combine status into one interrupt line
    assign irq_o = |sts_o;
endmodule

// File: rtl/mon_rx.sv
// Top of the handshake channel receiver. It tracks whether a message is in
// progress and whether a read is pending, captures bytes, and feeds the
// acknowledge sequencer and the status bank.
// Assumes rd_stb does not coincide with frame_stb, and all strobes are one cycle.
module mon_rx #(
    parameter int DATA_W     = 8,
    parameter int EOM_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              mx_n,
    input  logic              mrc,
    input  logic              mre,
    input  logic              rd_stb,
    input  logic              st_rd,
    output logic              mr_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              sts_mdr,
    output logic              sts_mer,
    output logic              irq
);
    localparam int N_STS   = 2;
    localparam int IDX_MDR = 0;
    localparam int IDX_MER = 1;

    logic start, gap1, eom;
    logic msg, pend;
    logic take_first, take_next, store;
    logic engaged, abort, ack_req;
    logic [N_STS-1:0] sts_set, sts;

    mon_rx_mxdet #(.EOM_FRAMES(EOM_FRAMES)) u_mxdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mx_n      (mx_n),
        .start_o   (start),
        .gap1_o    (gap1),
        .eom_o     (eom)
    );

    // Decide whether this frame's byte is taken and whether to abort
    always_comb begin
        take_first = start && !pend;
        take_next  = gap1 && msg && mrc && !pend;
        store      = take_first || take_next;
        abort      = frame_stb && !mrc && msg && engaged;
        ack_req    = rd_stb && pend;
        sts_set          = '0;
        sts_set[IDX_MDR] = take_first || (take_next && mre);
        sts_set[IDX_MER] = eom && msg && mre;
    end

    // Capture the byte and track the pending read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            pend    <= 1'b0;
        end else begin
            if (store)       rx_data <= rx_byte;
            if (store)       pend <= 1'b1;
            else if (rd_stb) pend <= 1'b0;
        end
    end

    // Track whether a message is in progress
    always_ff @(posedge clk) begin
        if (!rst_n)                      msg <= 1'b0;
        else if (take_first)             msg <= 1'b1;
        else if ((eom && msg) || abort)  msg <= 1'b0;
    end

    mon_rx_ack u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mrc       (mrc),
        .ack_req   (ack_req),
        .abort     (abort),
        .mr_n      (mr_n),
        .engaged   (engaged)
    );

    mon_rx_stat #(.N_STS(N_STS)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sts_set),
        .clr_i (st_rd),
        .sts_o (sts),
        .irq_o (irq)
    );

    assign sts_mdr = sts[IDX_MDR];
    assign sts_mer = sts[IDX_MER];

    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> $stable(rx_data));

    // R7
    mer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_mer) |-> $past(mre));

    // R9
    irq_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_stb));

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !rd_stb) |=> $stable(rx_data) && $stable(mr_n));
endmodule

// File: tb/mon_rx_test.sv
module mon_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       mx_n = 1'b1;
    logic       mrc = 1'b0;
    logic       mre = 1'b0;
    logic       rd_stb = 1'b0;
    logic       st_rd = 1'b0;
    logic       mr_n;
    logic [7:0] rx_data;
    logic       sts_mdr, sts_mer, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_run = 2, m_msg = 0, m_pend = 0, m_data = 0, m_mr = 1;
    int m_ack = 0, m_mdr = 0, m_mer = 0;

    always #4 clk = ~clk;

    mon_rx uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
        .mx_n(mx_n), .mrc(mrc), .mre(mre), .rd_stb(rd_stb), .st_rd(st_rd),
        .mr_n(mr_n), .rx_data(rx_data), .sts_mdr(sts_mdr), .sts_mer(sts_mer),
        .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model update and per-clock comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 2; m_msg = 0; m_pend = 0; m_data = 0; m_mr = 1;
            m_ack = 0; m_mdr = 0; m_mer = 0;
        end else begin
            bit f, s, g, e, eng, ab, tf, tn;
            int n_mr, n_ack;
            f   = frame_stb;
            s   = f && !mx_n && m_run == 2;
            g   = f && !mx_n && m_run == 1;
            e   = f && mx_n && m_run == 1;
            eng = (m_mr == 0) || (m_ack == 2);
            ab  = f && !mrc && m_msg != 0 && eng;
            tf  = s && m_pend == 0;
            tn  = g && m_msg != 0 && mrc && m_pend == 0;
            m_mdr = (tf || (tn && mre) || (m_mdr != 0 && !st_rd)) ? 1 : 0;
            m_mer = ((e && m_msg != 0 && mre) || (m_mer != 0 && !st_rd)) ? 1 : 0;
            n_mr = m_mr; n_ack = m_ack;
            if (f) begin
                if (!mrc) begin
                    n_mr = 1;
                    if (ab || m_ack == 2) n_ack = 0;
                end else if (m_ack == 1) begin
                    if (m_mr == 1) begin n_mr = 0; n_ack = 0; end
                    else begin n_mr = 1; n_ack = 2; end
                end else if (m_ack == 2) begin
                    n_mr = 0; n_ack = 0;
                end
            end
            if (rd_stb && m_pend != 0) n_ack = 1;
            m_mr = n_mr; m_ack = n_ack;
            if (f) m_run = mx_n ? ((m_run < 2) ? m_run + 1 : 2) : 0;
            if (tf || tn) m_data = rx_byte;
            if (tf || tn) m_pend = 1; else if (rd_stb) m_pend = 0;
            if (tf) m_msg = 1; else if ((e && m_msg != 0) || ab) m_msg = 0;
        end
        #2;
        check("R5 mr_n vs model", mr_n, m_mr);
        check("R2 rx_data vs model", rx_data, m_data);
        check("R9 sts_mdr vs model", sts_mdr, m_mdr);
        check("R7 sts_mer vs model", sts_mer, m_mer);
        check("R9 irq vs model", irq, (m_mdr != 0 || m_mer != 0) ? 1 : 0);
    end

    task automatic frame(input logic mx, input logic [7:0] b);
        @(negedge clk);
        mx_n = mx; rx_byte = b; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic do_stclr();
        @(negedge clk); st_rd = 1'b1;
        @(negedge clk); st_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 mr_n", mr_n, 1);
        check("R1 rx_data", rx_data, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;

        // first byte with mrc and mre low
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        frame(1'b0, 8'hA5);
        check("R2 first byte", rx_data, 8'hA5);
        check("R2 mdr unmasked", sts_mdr, 1);
        frame(1'b0, 8'hA5);
        mrc = 1'b1; mre = 1'b1;
        frame(1'b0, 8'hA5);
        check("R6 no ack before read", mr_n, 1);
        do_stclr();
        check("R9 clear on read", sts_mdr, 0);
        do_read();
        frame(1'b0, 8'hA5);
        check("R3 first ack direct", mr_n, 0);
        frame(1'b0, 8'h5A);
        check("R4 held flag no byte", rx_data, 8'hA5);

        // second byte after a single gap
        frame(1'b1, 8'h00);
        frame(1'b0, 8'h3C);
        check("R4 single gap byte", rx_data, 8'h3C);
        check("R4 mdr with mre", sts_mdr, 1);
        frame(1'b1, 8'h00);
        frame(1'b0, 8'h77);
        check("R6 no overwrite", rx_data, 8'h3C);
        check("R6 ack held", mr_n, 0);
        do_read();
        frame(1'b0, 8'h77);
        check("R5 inactive frame", mr_n, 1);
        frame(1'b0, 8'h77);
        check("R5 active again", mr_n, 0);
        do_stclr();

        // R10 flag and byte move without a strobe
        @(negedge clk); mx_n = 1'b1; rx_byte = 8'h99;
        repeat (3) @(negedge clk);
        mx_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 data unchanged", rx_data, 8'h3C);
        check("R10 status unchanged", sts_mdr, 0);

        // end of message
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        check("R7 mer set", sts_mer, 1);
        check("R9 irq from mer", irq, 1);
        do_stclr();
        check("R9 mer cleared", sts_mer, 0);
        mrc = 1'b0;
        frame(1'b1, 8'h00);
        check("R8 mrc low forces inactive", mr_n, 1);

        // abort mid-message
        mrc = 1'b1;
        frame(1'b0, 8'h11);
        check("R2 new message", rx_data, 8'h11);
        do_read();
        do_stclr();
        frame(1'b0, 8'h11);
        check("R3 ack second message", mr_n, 0);
        frame(1'b1, 8'h00);
        frame(1'b0, 8'h22);
        check("R4 byte stored", rx_data, 8'h22);
        do_read();
        frame(1'b0, 8'h22);
        frame(1'b0, 8'h22);
        do_stclr();
        mrc = 1'b0;
        frame(1'b0, 8'h22);
        check("R8 abort mr_n", mr_n, 1);
        frame(1'b1, 8'h00);
        frame(1'b0, 8'h33);
        check("R8 no store after abort", rx_data, 8'h22);
        check("R8 no mdr after abort", sts_mdr, 0);

        // mre low inside a message
        mre = 1'b0; mrc = 1'b1;
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        frame(1'b0, 8'h44);
        check("R2 first mdr ignores mre", sts_mdr, 1);
        do_stclr();
        do_read();
        frame(1'b0, 8'h44);
        check("R3 ack", mr_n, 0);
        frame(1'b1, 8'h00);
        frame(1'b0, 8'h55);
        check("R4 stored", rx_data, 8'h55);
        check("R4 mdr masked", sts_mdr, 0);
        do_read();
        frame(1'b0, 8'h55);
        frame(1'b0, 8'h55);
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        check("R7 mer masked", sts_mer, 0);
        check("R9 irq low", irq, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule